// File: doc/BRIEF.md
# Per-Vector Message Interrupt Table

This block holds a table of interrupt vectors that software programs through a word-addressed register port. Each vector carries its own 64-bit destination address, a 32-bit payload and a control word whose bit 0 masks the vector. A bit array, one bit per vector, records which vectors have an interrupt waiting. Logic inside the chip raises an interrupt by giving a vector number. The block then issues a memory write of that vector's payload to that vector's address on a valid/ready output. It issues the write only when the vector is unmasked and the whole function is enabled and not masked.

Several vectors can wait at once. The eligible ones are served one at a time in round-robin order. Only one message is in flight at a time, and it is held steady until the receiver accepts it. Masking a vector never drops its interrupt. The pending bit stays set, and the message goes out once the mask is lifted.

Top module: `msix_vector_table`

## Requirements
- R1: After reset every vector's mask bit is 1, its address and payload words read 0, every pending bit is 0 and `msg_valid` is low.
- R2: Vector n sits at word addresses 4n..4n+3: word +0 is address bits 31:0, +1 is address bits 63:32, +2 is the payload and +3 is control, where bit 0 is the mask and bits 31:1 read 0. Read data appears on `reg_rdata` with `reg_rvalid` high in the cycle after `reg_rd`. A read issued in the same cycle as a write to that word returns the old value.
- R3: The pending array starts at word address 4*NUM_VEC. Bit b of pending word w belongs to vector 32w+b. Writes to the pending array are ignored.
- R4: `irq_req` with vector v sets pending bit v from the next cycle. A request that arrives in the cycle the same vector's message is accepted leaves the bit set, so that vector sends again.
- R5: A masked vector keeps its pending bit and sends nothing. Once it is unmasked, its message is sent.
- R6: While `fn_enable` is low or `fn_mask` is high, no new message is launched, and the pending bits are preserved.
- R7: A message carries the vector's address {high, low} and its payload as they stood in the cycle it was launched. The address and payload are held unchanged while `msg_valid` is high and `msg_ready` is low.
- R8: A vector's pending bit clears in the cycle its message is accepted (`msg_valid` and `msg_ready` both high).
- R9: Eligible vectors (pending, unmasked) are served in round-robin order, starting at the vector after the one last launched. After reset, vector 0 comes first.
- R10: At most one message is outstanding. A message becomes valid in the cycle after its vector is pending and eligible while the output is idle. There is therefore one idle cycle after each acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address (table, then pending array) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| reg_rvalid | output | 1 | Read data valid |
| irq_req | input | 1 | Raise interrupt on `irq_vec` |
| irq_vec | input | VEC_W | Vector number of the request |
| fn_enable | input | 1 | Function-wide message enable |
| fn_mask | input | 1 | Function-wide mask |
| msg_valid | output | 1 | Message write is offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 64 | Destination address of the message |
| msg_data | output | 32 | Payload of the message |

## Verification
A pending bit that is wrong inside the block shows up in two places. It appears on the next read of the pending array, and it shows up within a cycle of becoming eligible as a missing or extra `msg_valid`. A stale round-robin pointer shows up as a different vector's payload on `msg_data` the first time two eligible vectors compete. A wrong table entry is visible both on read-back and in the address and payload of the vector's next message. Because of this, a bench that compares every output on every clock catches most faults within one or two cycles of the first stimulus that touches them.

// File: rtl/msix_pkg.sv
package msix_pkg;

    typedef enum logic [1:0] {
        FLD_ADDR_LO = 2'd0,
        FLD_ADDR_HI = 2'd1,
        FLD_DATA    = 2'd2,
        FLD_CTRL    = 2'd3
    } vec_field_e;

    typedef struct packed {
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        mask;
    } vec_entry_t;

    localparam vec_entry_t ENTRY_RST = '{addr_lo: 32'h0, addr_hi: 32'h0, data: 32'h0, mask: 1'b1};

endpackage

// File: rtl/msix_entry_store.sv
module msix_entry_store
    import msix_pkg::*;
#(
    parameter int unsigned NUM_VEC = 8,
    parameter int unsigned VEC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [VEC_W-1:0]   wr_idx_i,
    input  vec_field_e         wr_fld_i,
    input  logic [31:0]        wr_data_i,
    input  logic [VEC_W-1:0]   rd_idx_i,
    input  vec_field_e         rd_fld_i,
    output logic [31:0]        rd_data_o,
    input  logic [VEC_W-1:0]   ln_idx_i,
    output logic [63:0]        ln_addr_o,
    output logic [31:0]        ln_data_o,
    output logic [NUM_VEC-1:0] mask_o
);

    vec_entry_t tbl_d [NUM_VEC];
    vec_entry_t tbl_q [NUM_VEC];

    always_comb begin
        for (int n = 0; n < int'(NUM_VEC); n++) begin
            tbl_d[n] = tbl_q[n];
        end
        if (wr_i) begin
            unique case (wr_fld_i)
                FLD_ADDR_LO: tbl_d[wr_idx_i].addr_lo = wr_data_i;
                FLD_ADDR_HI: tbl_d[wr_idx_i].addr_hi = wr_data_i;
                FLD_DATA:    tbl_d[wr_idx_i].data    = wr_data_i;
                default:     tbl_d[wr_idx_i].mask    = wr_data_i[0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int n = 0; n < int'(NUM_VEC); n++) begin
            tbl_q[n] <= rst_n ? tbl_d[n] : ENTRY_RST;
        end
    end

    always_comb begin
        unique case (rd_fld_i)
            FLD_ADDR_LO: rd_data_o = tbl_q[rd_idx_i].addr_lo;
            FLD_ADDR_HI: rd_data_o = tbl_q[rd_idx_i].addr_hi;
            FLD_DATA:    rd_data_o = tbl_q[rd_idx_i].data;
            default:     rd_data_o = {31'h0, tbl_q[rd_idx_i].mask};
        endcase
    end

    assign ln_addr_o = {tbl_q[ln_idx_i].addr_hi, tbl_q[ln_idx_i].addr_lo};
    assign ln_data_o = tbl_q[ln_idx_i].data;

    for (genvar g = 0; g < int'(NUM_VEC); g++) begin : g_mask
        assign mask_o[g] = tbl_q[g].mask;
    end

endmodule

// File: rtl/msix_pending.sv
module msix_pending #(
    parameter int unsigned NUM_VEC = 8,
    parameter int unsigned VEC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_i,
    input  logic [VEC_W-1:0]   set_idx_i,
    input  logic               clr_i,
    input  logic [VEC_W-1:0]   clr_idx_i,
    output logic [NUM_VEC-1:0] pend_o
);

    logic [NUM_VEC-1:0] pend_d, pend_q;
    logic               set_ok;

    assign set_ok = set_i && (set_idx_i <= VEC_W'(NUM_VEC - 1));

    always_comb begin
        pend_d = pend_q;
        if (clr_i) pend_d[clr_idx_i] = 1'b0;
        if (set_ok) pend_d[set_idx_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        pend_q <= rst_n ? pend_d : '0;
    end

    assign pend_o = pend_q;

    // R4: a request is recorded by the next cycle
    p_set_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_ok |=> pend_q[$past(set_idx_i)]);

    // R8: acceptance clears the bit unless a fresh request for it arrives together
    p_accept_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !(set_ok && set_idx_i == clr_idx_i) |=> !pend_q[$past(clr_idx_i)]);

endmodule

// File: rtl/msix_rr_arb.sv
module msix_rr_arb #(
    parameter int unsigned NUM_VEC = 8,
    parameter int unsigned VEC_W   = 3
) (
    input  logic [NUM_VEC-1:0] req_i,
    input  logic [VEC_W-1:0]   last_i,
    output logic               gnt_valid_o,
    output logic [VEC_W-1:0]   gnt_idx_o
);

    always_comb begin
        int cand;
        gnt_valid_o = 1'b0;
        gnt_idx_o   = '0;
        for (int i = 0; i < int'(NUM_VEC); i++) begin
            cand = int'(last_i) + 1 + i;
            if (cand >= int'(NUM_VEC)) cand = cand - int'(NUM_VEC);
            if (!gnt_valid_o && req_i[VEC_W'(cand)]) begin
                gnt_valid_o = 1'b1;
                gnt_idx_o   = VEC_W'(cand);
            end
        end
    end

endmodule

// File: rtl/msix_vector_table.sv
module msix_vector_table
    import msix_pkg::*;
#(
    parameter  int unsigned NUM_VEC   = 8,
    localparam int unsigned VEC_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int unsigned TBL_WORDS = NUM_VEC * 4,
    localparam int unsigned PBA_WORDS = (NUM_VEC + 31) / 32,
    localparam int unsigned ADDR_W    = $clog2(TBL_WORDS + PBA_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              fn_enable,
    input  logic              fn_mask,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data
);

    localparam logic [ADDR_W-1:0] TBL_A = ADDR_W'(TBL_WORDS);

    typedef struct packed {
        logic             msg_valid;
        logic [63:0]      msg_addr;
        logic [31:0]      msg_data;
        logic [VEC_W-1:0] msg_vec;
        logic [VEC_W-1:0] last;
        logic             rvalid;
        logic [31:0]      rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               in_tbl;
    logic [VEC_W-1:0]   sw_idx;
    logic [31:0]        st_rdata;
    logic [63:0]        ln_addr;
    logic [31:0]        ln_data;
    logic [NUM_VEC-1:0] mask_w;
    logic [NUM_VEC-1:0] pend_w;
    logic [NUM_VEC-1:0] elig_w;
    logic               gnt_valid;
    logic [VEC_W-1:0]   gnt_idx;
    logic               accept;
    logic               launch;
    logic [ADDR_W-1:0]  pba_word_idx;
    logic [31:0]        pba_word;

    assign in_tbl = reg_addr < TBL_A;
    assign sw_idx = VEC_W'(reg_addr >> 2);

    msix_entry_store #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr && in_tbl),
        .wr_idx_i  (sw_idx),
        .wr_fld_i  (vec_field_e'(reg_addr[1:0])),
        .wr_data_i (reg_wdata),
        .rd_idx_i  (sw_idx),
        .rd_fld_i  (vec_field_e'(reg_addr[1:0])),
        .rd_data_o (st_rdata),
        .ln_idx_i  (gnt_idx),
        .ln_addr_o (ln_addr),
        .ln_data_o (ln_data),
        .mask_o    (mask_w)
    );

    assign accept = ctl_q.msg_valid && msg_ready;

    msix_pending #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) i_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (irq_req),
        .set_idx_i (irq_vec),
        .clr_i     (accept),
        .clr_idx_i (ctl_q.msg_vec),
        .pend_o    (pend_w)
    );

    assign elig_w = pend_w & ~mask_w;

    msix_rr_arb #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) i_arb (
        .req_i       (elig_w),
        .last_i      (ctl_q.last),
        .gnt_valid_o (gnt_valid),
        .gnt_idx_o   (gnt_idx)
    );

    assign launch = !ctl_q.msg_valid && fn_enable && !fn_mask && gnt_valid;

    assign pba_word_idx = reg_addr - TBL_A;

    always_comb begin
        pba_word = '0;
        for (int b = 0; b < 32; b++) begin
            if (int'(pba_word_idx) * 32 + b < int'(NUM_VEC)) begin
                pba_word[b] = pend_w[VEC_W'(int'(pba_word_idx) * 32 + b)];
            end
        end
    end

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = reg_rd;
        if (reg_rd) ctl_d.rdata = in_tbl ? st_rdata : pba_word;
        if (accept) ctl_d.msg_valid = 1'b0;
        if (launch) begin
            ctl_d.msg_valid = 1'b1;
            ctl_d.msg_addr  = ln_addr;
            ctl_d.msg_data  = ln_data;
            ctl_d.msg_vec   = gnt_idx;
            ctl_d.last      = gnt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.last <= VEC_W'(NUM_VEC - 1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign reg_rdata  = ctl_q.rdata;
    assign reg_rvalid = ctl_q.rvalid;
    assign msg_valid  = ctl_q.msg_valid;
    assign msg_addr   = ctl_q.msg_addr;
    assign msg_data   = ctl_q.msg_data;

    // R7: an offered message does not change until it is taken
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    // R6: nothing starts while the function is disabled or masked
    p_gate_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid && (!fn_enable || fn_mask) |=> !msg_valid);

    // R5: a launched vector was pending and unmasked one cycle earlier
    p_launch_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> |($past(elig_w) & (NUM_VEC'(1) << ctl_q.msg_vec)));

    // R10: after an acceptance the output goes idle for a cycle
    p_idle_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid);

endmodule

// File: tb/test_msix_vector_table.sv
`timescale 1ns/1ps
module test_msix_vector_table;

    localparam int N    = 8;
    localparam int VW   = 3;
    localparam int AW   = 6;
    localparam int PBA0 = N * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          reg_rvalid;
    logic          irq_req = 1'b0;
    logic [VW-1:0] irq_vec = '0;
    logic          fn_enable = 1'b1, fn_mask = 1'b0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [31:0] acc_q[$];

    always #2.5 clk = ~clk;

    msix_vector_table #(.NUM_VEC(N)) i_msix_vector_table (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .irq_req(irq_req), .irq_vec(irq_vec),
        .fn_enable(fn_enable), .fn_mask(fn_mask), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];
    logic [31:0] m_dat[N];
    bit          m_msk[N];
    bit          m_pnd[N];
    bit          m_valid, m_rvalid;
    logic [63:0] m_addr;
    logic [31:0] m_data, m_rdata;
    int          m_vec, m_last;

    function automatic logic [31:0] model_read(int a);
        logic [31:0] v = '0;
        if (a < PBA0) begin
            case (a % 4)
                0: v = m_lo[a / 4];
                1: v = m_hi[a / 4];
                2: v = m_dat[a / 4];
                default: v = {31'h0, m_msk[a / 4]};
            endcase
        end else begin
            for (int b = 0; b < 32; b++)
                if ((a - PBA0) * 32 + b < N) v[b] = m_pnd[(a - PBA0) * 32 + b];
        end
        return v;
    endfunction

    always @(posedge clk) begin
        bit acc, go;
        int pick;
        if (!rst_n) begin
            for (int n = 0; n < N; n++) begin
                m_lo[n] = 0; m_hi[n] = 0; m_dat[n] = 0; m_msk[n] = 1; m_pnd[n] = 0;
            end
            m_valid = 0; m_rvalid = 0; m_addr = 0; m_data = 0; m_rdata = 0;
            m_vec = 0; m_last = N - 1;
        end else begin
            acc  = m_valid && msg_ready;
            go   = 0;
            pick = 0;
            if (!m_valid && fn_enable && !fn_mask) begin
                for (int k = 1; k <= N; k++) begin
                    if (!go && m_pnd[(m_last + k) % N] && !m_msk[(m_last + k) % N]) begin
                        go = 1;
                        pick = (m_last + k) % N;
                    end
                end
            end
            m_rvalid = reg_rd;
            if (reg_rd) m_rdata = model_read(int'(reg_addr));
            if (go) begin
                m_addr = {m_hi[pick], m_lo[pick]};
                m_data = m_dat[pick];
            end
            if (reg_wr && int'(reg_addr) < PBA0) begin
                case (int'(reg_addr) % 4)
                    0: m_lo[int'(reg_addr) / 4] = reg_wdata;
                    1: m_hi[int'(reg_addr) / 4] = reg_wdata;
                    2: m_dat[int'(reg_addr) / 4] = reg_wdata;
                    default: m_msk[int'(reg_addr) / 4] = reg_wdata[0];
                endcase
            end
            if (acc) begin
                m_pnd[m_vec] = 0;
                m_valid = 0;
            end
            if (irq_req) m_pnd[irq_vec] = 1;
            if (go) begin
                m_valid = 1;
                m_vec = pick;
                m_last = pick;
            end
        end
    end

    // Compare against the model on every falling edge; log handshakes.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (msg_valid !== m_valid) begin
                failures++;
                $display("FAIL R10 msg_valid actual=%0b expected=%0b t=%0t", msg_valid, m_valid, $time);
            end
            if (m_valid) begin
                checks++;
                if (msg_addr !== m_addr || msg_data !== m_data) begin
                    failures++;
                    $display("FAIL R7 message actual=%h/%h expected=%h/%h", msg_addr, msg_data, m_addr, m_data);
                end
            end
            checks++;
            if (reg_rvalid !== m_rvalid || (m_rvalid && reg_rdata !== m_rdata)) begin
                failures++;
                $display("FAIL R2 read actual=%0b/%h expected=%0b/%h", reg_rvalid, reg_rdata, m_rvalid, m_rdata);
            end
            if (msg_valid && msg_ready) acc_q.push_back(msg_data);
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_rd = 1; reg_addr = AW'(a);
        @(posedge clk); #1;
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic irq(int v);
        @(posedge clk); #1;
        irq_req = 1; irq_vec = VW'(v);
        @(posedge clk); #1;
        irq_req = 0;
    endtask

    function automatic int count_data(logic [31:0] d);
        int c = 0;
        foreach (acc_q[i]) if (acc_q[i] == d) c++;
        return c;
    endfunction

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] r;
        step(3);
        rst_n = 1;
        step(2);
        chk("R1 msg_valid after reset", 64'(msg_valid), 64'(0));
        rd(3, r);        chk("R1 mask resets to 1", 64'(r), 64'(1));
        rd(0, r);        chk("R1 address low resets to 0", 64'(r), 64'(0));
        rd(PBA0, r);     chk("R1 pending resets to 0", 64'(r), 64'(0));

        for (int n = 0; n < N; n++) begin
            wr(4 * n,     32'h1000_0000 + 32'(n * 16));
            wr(4 * n + 1, 32'(n));
            wr(4 * n + 2, 32'hD000 + 32'(n));
        end
        rd(14, r);       chk("R2 payload word of vector 3", 64'(r), 64'h0000_D003);
        rd(13, r);       chk("R2 address high word of vector 3", 64'(r), 64'(3));
        wr(27, 32'hFFFF_FFFE);
        rd(27, r);       chk("R2 control reserved bits read 0", 64'(r), 64'(0));
        wr(27, 32'hFFFF_FFFF);
        rd(27, r);       chk("R2 control mask bit", 64'(r), 64'(1));

        irq(2);
        step(4);
        chk("R5 masked vector sends nothing", 64'(msg_valid), 64'(0));
        rd(PBA0, r);     chk("R5 masked vector stays pending (R3 bit 2)", 64'(r), 64'h4);
        wr(PBA0, 32'hFFFF_FFFF);
        rd(PBA0, r);     chk("R3 write to pending array ignored", 64'(r), 64'h4);

        wr(11, 32'h0);
        step(2);
        chk("R5 unmasked vector launches", 64'(msg_valid), 64'(1));
        chk("R7 message address", msg_addr, 64'h0000_0002_1000_0020);
        chk("R7 message payload", 64'(msg_data), 64'h0000_D002);
        step(3);
        chk("R7 address held while not ready", msg_addr, 64'h0000_0002_1000_0020);
        msg_ready = 1;
        step(1);
        msg_ready = 0;
        rd(PBA0, r);     chk("R8 pending cleared on accept", 64'(r), 64'(0));

        fn_enable = 0;
        for (int n = 0; n < N; n++) wr(4 * n + 3, 32'h0);
        irq(5);
        irq(1);
        step(4);
        chk("R6 disabled function sends nothing", 64'(msg_valid), 64'(0));
        rd(PBA0, r);     chk("R6 pending preserved while disabled", 64'(r), 64'h22);
        fn_enable = 1; fn_mask = 1;
        step(4);
        chk("R6 masked function sends nothing", 64'(msg_valid), 64'(0));
        msg_ready = 1;
        fn_mask = 0;
        step(10);
        chk("R9 order: count", 64'(acc_q.size()), 64'(3));
        if (acc_q.size() == 3) begin
            chk("R9 vector 5 served after 2", 64'(acc_q[1]), 64'h0000_D005);
            chk("R9 vector 1 served after 5", 64'(acc_q[2]), 64'h0000_D001);
        end

        msg_ready = 0;
        irq(4);
        step(3);
        chk("R10 vector 4 offered", 64'(msg_valid), 64'(1));
        msg_ready = 1; irq_req = 1; irq_vec = 3'd4;
        step(1);
        irq_req = 0;
        step(6);
        chk("R4 request at acceptance resends", 64'(count_data(32'hD004)), 64'(2));
        msg_ready = 0;
        rd(PBA0, r);     chk("R4 pending empty after resend", 64'(r), 64'(0));

        // mixed traffic, compared against the model every cycle
        for (int c = 0; c < 4000; c++) begin
            @(posedge clk); #1;
            irq_req   = ($urandom % 4) == 0;
            irq_vec   = VW'($urandom % N);
            msg_ready = ($urandom % 3) != 0;
            reg_wr    = 0;
            reg_rd    = ($urandom % 5) == 0;
            reg_addr  = AW'($urandom % (PBA0 + 1));
            if (($urandom % 16) == 0) begin
                reg_wr    = 1;
                reg_addr  = AW'(4 * ($urandom % N) + (($urandom % 2) == 0 ? 3 : 2));
                reg_wdata = $urandom;
                if (($urandom % 8) == 0) reg_addr = AW'(PBA0);
            end
            if (($urandom % 64) == 0) fn_mask = ~fn_mask;
            if (($urandom % 97) == 0) fn_enable = ~fn_enable;
        end
        @(posedge clk); #1;
        reg_wr = 0; reg_rd = 0; irq_req = 0;
        step(4);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule